// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds the architectural floating-point registers of a core: 32 words of 32 bits, kept as two banks of 16. It also holds a mode register and a 32-bit communication register that passes words between the floating-point and integer sides. Each instruction addresses a logical register index of 0 to 15. Three mode bits set how that index reaches storage. The bank bit picks which half is visible. The pair-move bit turns moves into 64-bit transfers of register pairs. The precision bit is kept and toggled for the arithmetic units that sit beside the file.

One operation is issued per cycle on `op_code`. Loads take their data from the two memory words at the base address and at base+4, which the load/store unit presents. Stores drive the same two word slots. Post-increment loads and pre-decrement stores also return an updated address for the integer register that holds the pointer. Four bit-level operations run inside the block: negate, absolute value, load zero and load one. Two combinational read ports and one pair view serve the arithmetic units. A write is forwarded to a read of the same register in the same cycle. The block contains no arithmetic, rounding, bus or trap logic.

Top module: `fprf_top`

## Requirements
- R1: A mode write (op 13) stores `wdata & 0x003FFFFF`. Bit 21 is bank, bit 20 is pair-move, bit 19 is precision, bit 18 is denormal handling, and bits [1:0] are rounding. Bits 31..22 of `mode_out` always read zero.
- R2: After reset, every register reads zero, `comm_out` is zero and `mode_out` equals `MODE_RST` (default 0x00040001).
- R3: Logical index n reaches physical register n when bank bit 21 is clear, and n+16 (n XOR 16) when it is set. This holds for both read ports and for single-word writes.
- R4: `rd_a_pair` is {physical even register in [63:32], physical odd register in [31:0]} of the pair that holds port A's register after bank selection.
- R5: With pair-move bit 20 set, an even index n names the pair (n, n+1) in the current bank. An odd index n names the pair (n-1, n) in the opposite bank.
- R6: Load (op 2, 3) in single mode writes `ld_base`. In pair mode it writes `ld_plus4` to the even register and `ld_base` to the odd register. Store (op 4, 5) drives `st_base` with the single register, and `st_plus4` reads zero in single mode. In pair mode `st_plus4` carries the even register and `st_base` the odd register.
- R7: Op 3 sets `addr_wb_en` with `addr_wb = addr_in + step` and `mem_addr = addr_in`. Op 5 sets `addr_wb_en` with `addr_wb = mem_addr = addr_in - step`. Here step is 8 in pair mode and 4 otherwise. Op 2 and op 4 use `mem_addr = addr_in` with `addr_wb_en` low.
- R8: A register move (op 1) copies register m to register n in single mode. In pair mode it copies both words of pair m into pair n.
- R9: Op 10 inverts bit 20, op 11 inverts bit 19 and op 12 inverts bit 21. No other mode bit changes.
- R10: On single register n (bank applied, pair mode ignored), op 6 flips bit 31, op 7 clears bit 31, op 8 writes 0 and op 9 writes 0x3F800000.
- R11: Op 14 loads `wdata` into the communication register. Op 15 copies register n into it, and op 16 copies it into register n.
- R12: A read port or `rd_a_pair` addressing a register being written in the same cycle shows the new value. The stored value from the next cycle on is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (0 = no operation) |
| op_n | input | 4 | Destination / single-operand logical index |
| op_m | input | 4 | Source logical index |
| wdata | input | 32 | Data for mode and communication writes |
| addr_in | input | 32 | Current pointer value for loads and stores |
| ld_base | input | 32 | Memory word at the base address |
| ld_plus4 | input | 32 | Memory word at base address + 4 |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_a_data | output | 32 | Read port A data, forwarded |
| rd_b_data | output | 32 | Read port B data, forwarded |
| rd_a_pair | output | 64 | Even/odd pair containing port A's register |
| mem_addr | output | 32 | Access base address |
| st_base | output | 32 | Store word for the base address |
| st_plus4 | output | 32 | Store word for base address + 4 |
| addr_wb_en | output | 1 | Pointer update valid |
| addr_wb | output | 32 | Updated pointer value |
| mode_out | output | 32 | Mode register |
| comm_out | output | 32 | Communication register |

## Verification
A register write and a read of the same register can land in the same cycle. This includes a pair write seen through both read ports and the pair view. The bench provokes the case by aiming `rd_a_idx` and `rd_b_idx` at the destination of loads, moves, bit operations and transfers as they are issued. It expects the new word on the ports in that cycle, and the same word on a plain read one cycle later. Bank and pair-move toggles are mixed in so that the forwarded register is the remapped physical one, not the logical index.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int MODE_VALID_BITS = 22;
    localparam int MB_DENORM       = 18;
    localparam int MB_DOUBLE       = 19;
    localparam int MB_PAIRMOVE     = 20;
    localparam int MB_BANK         = 21;

    typedef enum logic [4:0] {
        OP_NOP       = 5'd0,
        OP_MOV       = 5'd1,
        OP_LOAD      = 5'd2,
        OP_LOAD_INC  = 5'd3,
        OP_STORE     = 5'd4,
        OP_STORE_DEC = 5'd5,
        OP_NEG       = 5'd6,
        OP_ABS       = 5'd7,
        OP_ZERO      = 5'd8,
        OP_ONE       = 5'd9,
        OP_TGL_PAIR  = 5'd10,
        OP_TGL_DBL   = 5'd11,
        OP_TGL_BANK  = 5'd12,
        OP_MODE_WR   = 5'd13,
        OP_COMM_WR   = 5'd14,
        OP_REG2COMM  = 5'd15,
        OP_COMM2REG  = 5'd16
    } fprf_op_e;

endpackage

// File: rtl/fprf_idx_map.sv
module fprf_idx_map #(
    parameter int LIDX_W = 4
) (
    input  logic [LIDX_W-1:0] lidx,
    input  logic              bank,
    input  logic              pair_move,
    output logic [LIDX_W:0]   phys
);
    always_comb begin
        if (pair_move) begin
            // odd index: step to the even slot and cross to the other bank
            phys = {bank ^ lidx[0], lidx[LIDX_W-1:1], 1'b0};
        end else begin
            phys = {bank, lidx};
        end
    end
endmodule

// File: rtl/fprf_unary.sv
module fprf_unary
    import fprf_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter logic [DATA_W-1:0] ONE_WORD = 32'h3F80_0000
) (
    input  fprf_op_e          op,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (op)
            OP_NEG:  res = {~src[DATA_W-1], src[DATA_W-2:0]};
            OP_ABS:  res = {1'b0, src[DATA_W-2:0]};
            OP_ONE:  res = ONE_WORD;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/fprf_top.sv
module fprf_top
    import fprf_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter int                BANK_REGS = 16,
    parameter logic [DATA_W-1:0] MODE_RST  = 32'h0004_0001,
    parameter logic [DATA_W-1:0] ONE_WORD  = 32'h3F80_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [4:0]               op_code,
    input  logic [$clog2(BANK_REGS)-1:0] op_n,
    input  logic [$clog2(BANK_REGS)-1:0] op_m,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [DATA_W-1:0]        ld_base,
    input  logic [DATA_W-1:0]        ld_plus4,
    input  logic [$clog2(BANK_REGS)-1:0] rd_a_idx,
    input  logic [$clog2(BANK_REGS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]        rd_a_data,
    output logic [DATA_W-1:0]        rd_b_data,
    output logic [2*DATA_W-1:0]      rd_a_pair,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        st_base,
    output logic [DATA_W-1:0]        st_plus4,
    output logic                     addr_wb_en,
    output logic [ADDR_W-1:0]        addr_wb,
    output logic [DATA_W-1:0]        mode_out,
    output logic [DATA_W-1:0]        comm_out
);
    localparam int LIDX_W = $clog2(BANK_REGS);
    localparam int PIDX_W = LIDX_W + 1;
    localparam int NPHYS  = 2 * BANK_REGS;
    localparam int NMAP   = 6;
    localparam logic [DATA_W-1:0] MODE_MASK =
        {{(DATA_W-MODE_VALID_BITS){1'b0}}, {MODE_VALID_BITS{1'b1}}};
    localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(DATA_W / 8);
    localparam logic [ADDR_W-1:0] STEP_PAIR = ADDR_W'(DATA_W / 4);

    typedef struct packed {
        logic [NPHYS-1:0][DATA_W-1:0] rf;
        logic [DATA_W-1:0]            mode;
        logic [DATA_W-1:0]            comm;
    } state_t;

    state_t   st_d, st_q;
    fprf_op_e op;
    logic     bank_sel, pair_mode;
    logic [DATA_W-1:0] unary_res;

    assign op        = fprf_op_e'(op_code);
    assign bank_sel  = st_q.mode[MB_BANK];
    assign pair_mode = st_q.mode[MB_PAIRMOVE];

    // map slots: 0 read A, 1 read B, 2 n single, 3 m single, 4 n pair, 5 m pair
    logic [NMAP-1:0][LIDX_W-1:0] map_in;
    logic [NMAP-1:0]             map_pm;
    logic [NMAP-1:0][PIDX_W-1:0] map_out;

    assign map_in = {op_m, op_n, op_m, op_n, rd_b_idx, rd_a_idx};
    assign map_pm = {{2{pair_mode}}, 4'b0000};

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        fprf_idx_map #(.LIDX_W(LIDX_W)) u_map (
            .lidx      (map_in[g]),
            .bank      (bank_sel),
            .pair_move (map_pm[g]),
            .phys      (map_out[g])
        );
    end

    logic [PIDX_W-1:0] pa, pb, pn, pm, en_even, en_odd, em_even, em_odd, pa_even, pa_odd;
    assign pa      = map_out[0];
    assign pb      = map_out[1];
    assign pn      = map_out[2];
    assign pm      = map_out[3];
    assign en_even = map_out[4];
    assign en_odd  = map_out[4] | PIDX_W'(1);
    assign em_even = map_out[5];
    assign em_odd  = map_out[5] | PIDX_W'(1);
    assign pa_even = {pa[PIDX_W-1:1], 1'b0};
    assign pa_odd  = pa | PIDX_W'(1);

    fprf_unary #(.DATA_W(DATA_W), .ONE_WORD(ONE_WORD)) u_unary (
        .op  (op),
        .src (st_q.rf[pn]),
        .res (unary_res)
    );

    logic              wr0_en, wr1_en;
    logic [PIDX_W-1:0] wr0_idx, wr1_idx;
    logic [DATA_W-1:0] wr0_data, wr1_data;
    logic [ADDR_W-1:0] step;

    always_comb begin
        st_d       = st_q;
        wr0_en     = 1'b0;
        wr0_idx    = pn;
        wr0_data   = '0;
        wr1_en     = 1'b0;
        wr1_idx    = en_odd;
        wr1_data   = '0;
        step       = pair_mode ? STEP_PAIR : STEP_ONE;
        mem_addr   = addr_in;
        addr_wb_en = 1'b0;
        addr_wb    = addr_in;
        st_base    = pair_mode ? st_q.rf[em_odd] : st_q.rf[pm];
        st_plus4   = pair_mode ? st_q.rf[em_even] : '0;
        if (op_valid) begin
            case (op)
                OP_MOV: begin
                    wr0_en = 1'b1;
                    if (pair_mode) begin
                        wr0_idx  = en_even;
                        wr0_data = st_q.rf[em_even];
                        wr1_en   = 1'b1;
                        wr1_data = st_q.rf[em_odd];
                    end else begin
                        wr0_data = st_q.rf[pm];
                    end
                end
                OP_LOAD, OP_LOAD_INC: begin
                    wr0_en = 1'b1;
                    if (pair_mode) begin
                        wr0_idx  = en_even;
                        wr0_data = ld_plus4;
                        wr1_en   = 1'b1;
                        wr1_data = ld_base;
                    end else begin
                        wr0_data = ld_base;
                    end
                    if (op == OP_LOAD_INC) begin
                        addr_wb_en = 1'b1;
                        addr_wb    = addr_in + step;
                    end
                end
                OP_STORE_DEC: begin
                    addr_wb_en = 1'b1;
                    addr_wb    = addr_in - step;
                    mem_addr   = addr_in - step;
                end
                OP_NEG, OP_ABS, OP_ZERO, OP_ONE: begin
                    wr0_en   = 1'b1;
                    wr0_data = unary_res;
                end
                OP_TGL_PAIR: st_d.mode[MB_PAIRMOVE] = ~st_q.mode[MB_PAIRMOVE];
                OP_TGL_DBL:  st_d.mode[MB_DOUBLE]   = ~st_q.mode[MB_DOUBLE];
                OP_TGL_BANK: st_d.mode[MB_BANK]     = ~st_q.mode[MB_BANK];
                OP_MODE_WR:  st_d.mode = wdata & MODE_MASK;
                OP_COMM_WR:  st_d.comm = wdata;
                OP_REG2COMM: st_d.comm = st_q.rf[pn];
                OP_COMM2REG: begin
                    wr0_en   = 1'b1;
                    wr0_data = st_q.comm;
                end
                default: ;
            endcase
        end
        if (wr0_en) st_d.rf[wr0_idx] = wr0_data;
        if (wr1_en) st_d.rf[wr1_idx] = wr1_data;
        // reads see next-state storage: same-cycle writes are forwarded
        rd_a_data = st_d.rf[pa];
        rd_b_data = st_d.rf[pb];
        rd_a_pair = {st_d.rf[pa_even], st_d.rf[pa_odd]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rf   <= '0;
            st_q.mode <= MODE_RST;
            st_q.comm <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_out = st_q.mode;
    assign comm_out = st_q.comm;

    assert_mode_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_out[DATA_W-1:MODE_VALID_BITS] == '0);

    assert_bank_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_TGL_BANK) |=>
        (mode_out[MB_BANK] != $past(mode_out[MB_BANK]) &&
         mode_out[MB_PAIRMOVE] == $past(mode_out[MB_PAIRMOVE])));

    assert_dec_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_STORE_DEC) |-> (addr_wb_en && addr_wb == mem_addr));

    assert_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_LOAD || op == OP_STORE)) |-> !addr_wb_en);

    assert_fwd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && $past(op_valid && op == OP_LOAD && !mode_out[MB_PAIRMOVE]
                            && op_n == rd_a_idx)
         && $stable(rd_a_idx) && $stable(mode_out)) |-> rd_a_data == $past(rd_a_data));

    assert_unary_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ABS && op_n == rd_a_idx) |-> !rd_a_data[DATA_W-1]);

endmodule

// File: tb/fprf_top_tb.sv
`timescale 1ns/100ps
module fprf_top_tb;
    import fprf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [3:0]  op_n = '0, op_m = '0, rd_a_idx = '0, rd_b_idx = '0;
    logic [31:0] wdata = '0, addr_in = '0, ld_base = '0, ld_plus4 = '0;
    logic [31:0] rd_a_data, rd_b_data, mem_addr, st_base, st_plus4, addr_wb, mode_out, comm_out;
    logic [63:0] rd_a_pair;
    logic        addr_wb_en;

    always #2.5 clk = ~clk;

    fprf_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_n(op_n), .op_m(op_m), .wdata(wdata), .addr_in(addr_in),
        .ld_base(ld_base), .ld_plus4(ld_plus4), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_a_pair(rd_a_pair),
        .mem_addr(mem_addr), .st_base(st_base), .st_plus4(st_plus4),
        .addr_wb_en(addr_wb_en), .addr_wb(addr_wb), .mode_out(mode_out), .comm_out(comm_out)
    );

    typedef struct { int sel; logic [63:0] exp; string req; } item_t;
    item_t sbq[$];
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] rf_m [32];
    logic [31:0] mode_m = 32'h0004_0001;
    logic [31:0] comm_m = '0;

    function automatic void push(int sel, logic [63:0] e, string r);
        item_t it;
        it.sel = sel; it.exp = e; it.req = r;
        sbq.push_back(it);
    endfunction

    function automatic logic [63:0] pick(int sel);
        case (sel)
            0: return {32'd0, rd_a_data};
            1: return {32'd0, rd_b_data};
            2: return rd_a_pair;
            3: return {32'd0, mem_addr};
            4: return {32'd0, st_base};
            5: return {32'd0, st_plus4};
            6: return {31'd0, addr_wb_en, addr_wb};
            7: return {32'd0, mode_out};
            8: return {32'd0, comm_out};
            default: return {63'd0, addr_wb_en};
        endcase
    endfunction

    // monitor: compares every queued item against the live outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sbq.pop_front();
                act = pick(it.sel);
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s (output %0d): actual %h expected %h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic issue(input string req, input fprf_op_e op, input logic [3:0] n,
                         input logic [3:0] m, input logic [31:0] wd, input logic [31:0] ad,
                         input logic [31:0] lb, input logic [31:0] lp,
                         input logic [3:0] ra, input logic [3:0] rb);
        logic [31:0] nx [32];
        logic [31:0] nmode, ncomm, step;
        logic fr, sz;
        logic [4:0] pn, pm, en, em;
        @(negedge clk);
        op_valid = (op != OP_NOP); op_code = op; op_n = n; op_m = m;
        wdata = wd; addr_in = ad; ld_base = lb; ld_plus4 = lp;
        rd_a_idx = ra; rd_b_idx = rb;
        nx = rf_m; nmode = mode_m; ncomm = comm_m;
        fr = mode_m[21]; sz = mode_m[20]; step = sz ? 32'd8 : 32'd4;
        pn = {fr, n}; pm = {fr, m};
        en = {fr ^ n[0], n[3:1], 1'b0}; em = {fr ^ m[0], m[3:1], 1'b0};
        case (op)
            OP_MOV: if (sz) begin nx[en] = rf_m[em]; nx[en | 5'd1] = rf_m[em | 5'd1]; end
                    else nx[pn] = rf_m[pm];
            OP_LOAD, OP_LOAD_INC: begin
                if (sz) begin nx[en] = lp; nx[en | 5'd1] = lb; end
                else nx[pn] = lb;
                push(3, {32'd0, ad}, "R7 load address");
                if (op == OP_LOAD_INC) push(6, {31'd0, 1'b1, ad + step}, "R7 post-increment");
                else push(9, 64'd0, "R7 no update on plain load");
            end
            OP_STORE, OP_STORE_DEC: begin
                push(4, {32'd0, sz ? rf_m[em | 5'd1] : rf_m[pm]}, "R6 store base word");
                push(5, {32'd0, sz ? rf_m[em] : 32'd0}, "R6 store +4 word");
                if (op == OP_STORE_DEC) begin
                    push(3, {32'd0, ad - step}, "R7 pre-decrement address");
                    push(6, {31'd0, 1'b1, ad - step}, "R7 pre-decrement update");
                end else begin
                    push(3, {32'd0, ad}, "R7 store address");
                    push(9, 64'd0, "R7 no update on plain store");
                end
            end
            OP_NEG:      nx[pn] = rf_m[pn] ^ 32'h8000_0000;
            OP_ABS:      nx[pn] = rf_m[pn] & 32'h7FFF_FFFF;
            OP_ZERO:     nx[pn] = 32'h0;
            OP_ONE:      nx[pn] = 32'h3F80_0000;
            OP_TGL_PAIR: nmode[20] = ~mode_m[20];
            OP_TGL_DBL:  nmode[19] = ~mode_m[19];
            OP_TGL_BANK: nmode[21] = ~mode_m[21];
            OP_MODE_WR:  nmode = wd & 32'h003F_FFFF;
            OP_COMM_WR:  ncomm = wd;
            OP_REG2COMM: ncomm = rf_m[pn];
            OP_COMM2REG: nx[pn] = comm_m;
            default: ;
        endcase
        push(0, {32'd0, nx[{fr, ra}]}, {req, " port A"});
        push(1, {32'd0, nx[{fr, rb}]}, {req, " port B"});
        push(2, {nx[{fr, ra[3:1], 1'b0}], nx[{fr, ra[3:1], 1'b1}]}, {req, " R4 pair view"});
        push(7, {32'd0, mode_m}, {req, " mode"});
        push(8, {32'd0, comm_m}, {req, " comm"});
        rf_m = nx; mode_m = nmode; comm_m = ncomm;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        issue("R2 reset", OP_NOP, 0, 0, 0, 0, 0, 0, 0, 15);
        issue("R1 masked write", OP_MODE_WR, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 1, 2);
        issue("R1 readback", OP_NOP, 0, 0, 0, 0, 0, 0, 1, 2);
        issue("R1 restore", OP_MODE_WR, 0, 0, 32'h0004_0001, 0, 0, 0, 0, 0);
        issue("R12 load fwd", OP_LOAD, 3, 0, 0, 32'h100, 32'hA1A1_0003, 32'h0, 3, 3);
        issue("R12 hold", OP_NOP, 0, 0, 0, 0, 0, 0, 3, 2);
        issue("R7 load inc", OP_LOAD_INC, 4, 0, 0, 32'h200, 32'hB4B4_0004, 32'h0, 4, 3);
        issue("R9 bank toggle", OP_TGL_BANK, 0, 0, 0, 0, 0, 0, 3, 4);
        issue("R3 bank1 empty", OP_NOP, 0, 0, 0, 0, 0, 0, 3, 4);
        issue("R3 bank1 load", OP_LOAD, 3, 0, 0, 32'h120, 32'hC3C3_0013, 32'h0, 3, 4);
        issue("R9 bank back", OP_TGL_BANK, 0, 0, 0, 0, 0, 0, 3, 4);
        issue("R3 bank0 kept", OP_NOP, 0, 0, 0, 0, 0, 0, 3, 4);
        issue("R9 pair toggle", OP_TGL_PAIR, 0, 0, 0, 0, 0, 0, 6, 7);
        issue("R6 pair load inc", OP_LOAD_INC, 6, 0, 0, 32'h300, 32'hD0D0_BA5E, 32'hD4D4_0004, 6, 7);
        issue("R5 odd pair load", OP_LOAD, 9, 0, 0, 32'h340, 32'hE9E9_BA5E, 32'hE9E9_0004, 9, 8);
        issue("R9 bank toggle", OP_TGL_BANK, 0, 0, 0, 0, 0, 0, 8, 9);
        issue("R5 other bank pair", OP_NOP, 0, 0, 0, 0, 0, 0, 8, 9);
        issue("R9 bank back", OP_TGL_BANK, 0, 0, 0, 0, 0, 0, 6, 7);
        issue("R6 pair store dec", OP_STORE_DEC, 0, 6, 0, 32'h400, 0, 0, 6, 7);
        issue("R8 pair move", OP_MOV, 10, 6, 0, 0, 0, 0, 10, 11);
        issue("R5 odd source move", OP_MOV, 12, 9, 0, 0, 0, 0, 12, 13);
        issue("R6 odd pair store", OP_STORE, 0, 9, 0, 32'h480, 0, 0, 12, 13);
        issue("R9 pair off", OP_TGL_PAIR, 0, 0, 0, 0, 0, 0, 3, 4);
        issue("R7 single store dec", OP_STORE_DEC, 0, 3, 0, 32'h500, 0, 0, 3, 4);
        issue("R8 single move", OP_MOV, 15, 3, 0, 0, 0, 0, 15, 3);
        issue("R10 negate", OP_NEG, 3, 0, 0, 0, 0, 0, 3, 15);
        issue("R10 abs", OP_ABS, 3, 0, 0, 0, 0, 0, 3, 15);
        issue("R10 zero", OP_ZERO, 4, 0, 0, 0, 0, 0, 4, 3);
        issue("R10 one", OP_ONE, 5, 0, 0, 0, 0, 0, 5, 4);
        issue("R11 comm write", OP_COMM_WR, 0, 0, 32'h1234_5678, 0, 0, 0, 14, 5);
        issue("R11 comm to reg", OP_COMM2REG, 14, 0, 0, 0, 0, 0, 14, 5);
        issue("R11 reg to comm", OP_REG2COMM, 5, 0, 0, 0, 0, 0, 14, 5);
        issue("R11 comm read", OP_NOP, 0, 0, 0, 0, 0, 0, 14, 5);
        issue("R9 precision toggle", OP_TGL_DBL, 0, 0, 0, 0, 0, 0, 5, 14);
        issue("R9 precision read", OP_NOP, 0, 0, 0, 0, 0, 0, 5, 14);
        issue("R12 negate fwd", OP_NEG, 5, 0, 0, 0, 0, 0, 5, 5);
        issue("R9 bank toggle", OP_TGL_BANK, 0, 0, 0, 0, 0, 0, 2, 3);
        issue("R3 bank1 one", OP_ONE, 2, 0, 0, 0, 0, 0, 2, 3);
        issue("R9 bank back", OP_TGL_BANK, 0, 0, 0, 0, 0, 0, 2, 3);
        issue("R3 bank0 untouched", OP_NOP, 0, 0, 0, 0, 0, 0, 2, 3);
        issue("drain", OP_NOP, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule